// File: doc/BRIEF.md
# Programmable Parallel Port Controller

A host-side peripheral with three 8-bit ports, A, B and C, set up through one control register. The host reaches it over a small synchronous register bus. The bus has a chip select, a one-cycle read strobe, a one-cycle write strobe and a 2-bit register address (0 = port A, 1 = port B, 2 = port C, 3 = control). Each port has separate input, output and output-enable vectors instead of tri-state pads. This keeps the block usable inside a larger die.

Port A can run as a plain latched-output/live-input port, as a strobed handshake port, or as a bidirectional port. Port B can run as a plain port or as a handshake port. Port C changes role with the modes of A and B. Pins that no handshake claims stay general I/O, with one direction bit for each nibble. Claimed pins carry handshake flags, interrupt requests, or the strobe and acknowledge inputs from the peripheral.

The control address accepts two word formats. A mode word reconfigures everything and clears the port state. A single-pin word sets or clears one port C pin, or arms an interrupt enable.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset, no port bit is driven (pa_oe, pb_oe and pc_oe are all zero), irq_a and irq_b are low, and reading the control address returns 0xF4.
- R2: A control write with bit 7 = 1 is a mode word. Its fields are:
  - bits 1:0: port A mode (00 plain, 01 handshake, 1x bidirectional)
  - bit 2: port A is an input
  - bit 3: port B handshake
  - bit 4: port B is an input
  - bit 5: port C bits 3:0 are inputs
  - bit 6: port C bits 7:4 are inputs

  Writing a mode word clears every output latch, flag and interrupt enable. Reading the control address returns the last mode word.
- R3: A plain output port drives its last written value with all enables set from the cycle after the write, and a read of that port returns the written value.
- R4: A plain input port is not latched: a read returns the current pin value.
- R5: With both A and B plain, the two nibbles of port C follow their own direction bits. A read of C returns the latch on output nibbles and the pins on input nibbles.
- R6: A control write with bit 7 = 0 is a single-pin word. Bits 3:1 select a port C pin and bit 0 gives its new value. The latch of that pin changes and no other pin changes.
- R7: Handshake input uses the active-low strobe on C4 for A and on C2 for B. While the strobe is low, the port pins are captured and the buffer-full flag is set (C5 for A, C1 for B, high = full). The captured value is held after the pins change, and a host read of the port returns it and clears the flag.
- R8: In handshake input, the interrupt (C3 and irq_a for A, C0 and irq_b for B) rises in the cycle after the strobe returns high, but only if it was armed. A single-pin word aimed at the strobe pin (C4 for A, C2 for B) writes the enable. A host read of the port clears the interrupt.
- R9: In handshake output, a host write drives the output-full pin low (C6 for A, C1 for B). An active-low acknowledge (C7 for A, C2 for B) while full drives it high again and raises the interrupt if armed. A single-pin word on the acknowledge pin (C7 for A, C2 for B) writes the enable. The next host write clears the interrupt.
- R10: In bidirectional mode, port A drives only while C7 is low. C4 strobes input capture as in R7. C3, C5 and C6 carry the interrupt and both buffer flags, and C0 to C2 stay general I/O.
- R11: In handshake modes, flag and interrupt pins are always driven and strobe/acknowledge pins are never driven. The remaining port C pins follow their nibble direction bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle |
| wr | input | 1 | Write strobe, one cycle |
| addr | input | 2 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the addressed register |
| pa_in | input | DW | Port A pins in |
| pa_out | output | DW | Port A pins out |
| pa_oe | output | DW | Port A output enables |
| pb_in | input | DW | Port B pins in |
| pb_out | output | DW | Port B pins out |
| pb_oe | output | DW | Port B output enables |
| pc_in | input | 8 | Port C pins in |
| pc_out | output | 8 | Port C pins out |
| pc_oe | output | 8 | Port C output enables |
| irq_a | output | 1 | Port A interrupt request |
| irq_b | output | 1 | Port B interrupt request |

## Verification
The hardest state to reach is an armed interrupt in the bidirectional mode. To get there, the stimulus writes the mode word, then a single-pin word aimed at a strobe pin, then a full strobe pulse. The interrupt appears only one cycle after the strobe returns high.

The drive window of port A in that mode lasts only while the acknowledge pin is held low. The stimulus holds it low between two falling edges and samples the enables inside that window. It then checks that the buffer flag has already dropped once the pin is released.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

    // Control word in mode-set form (bit 7 set).
    typedef struct packed {
        logic       is_mode;
        logic       c_hi_in;
        logic       c_lo_in;
        logic       b_in;
        logic       b_hand;
        logic       a_in;
        logic [1:0] a_mode;
    } cfg_t;

    localparam cfg_t CFG_RESET = cfg_t'(8'hF4);

    localparam int unsigned CW  = 8;   // port C width
    localparam int unsigned NCH = 2;   // handshake channels (A, B)

    localparam logic [1:0] REG_A   = 2'd0;
    localparam logic [1:0] REG_B   = 2'd1;
    localparam logic [1:0] REG_C   = 2'd2;
    localparam logic [1:0] REG_CTL = 2'd3;

    // Port C pin roles in handshake modes.
    localparam int unsigned PIN_B_IRQ  = 0;
    localparam int unsigned PIN_B_FLAG = 1;
    localparam int unsigned PIN_B_HS   = 2;
    localparam int unsigned PIN_A_IRQ  = 3;
    localparam int unsigned PIN_A_STB  = 4;
    localparam int unsigned PIN_A_IBF  = 5;
    localparam int unsigned PIN_A_OBF  = 6;
    localparam int unsigned PIN_A_ACK  = 7;

endpackage

// File: rtl/ppio_role_decode.sv
module ppio_role_decode
    import ppio_pkg::*;
(
    input  cfg_t          cfg,
    output logic          a_hs_in,
    output logic          a_hs_out,
    output logic          a_bidir,
    output logic          b_hs_in,
    output logic          b_hs_out,
    output logic [CW-1:0] stat_mask,
    output logic [CW-1:0] strobe_mask,
    output logic [CW-1:0] drive_mask
);

    logic a_hand;

    always_comb begin
        a_bidir  = cfg.a_mode[1];
        a_hand   = (cfg.a_mode == 2'b01);
        a_hs_in  = a_bidir | (a_hand & cfg.a_in);
        a_hs_out = a_bidir | (a_hand & ~cfg.a_in);
        b_hs_in  = cfg.b_hand & cfg.b_in;
        b_hs_out = cfg.b_hand & ~cfg.b_in;

        stat_mask   = '0;
        strobe_mask = '0;
        if (a_hs_in || a_hs_out) begin
            stat_mask[PIN_A_IRQ] = 1'b1;
        end
        if (a_hs_in) begin
            stat_mask[PIN_A_IBF]   = 1'b1;
            strobe_mask[PIN_A_STB] = 1'b1;
        end
        if (a_hs_out) begin
            stat_mask[PIN_A_OBF]   = 1'b1;
            strobe_mask[PIN_A_ACK] = 1'b1;
        end
        if (cfg.b_hand) begin
            stat_mask[PIN_B_IRQ]  = 1'b1;
            stat_mask[PIN_B_FLAG] = 1'b1;
            strobe_mask[PIN_B_HS] = 1'b1;
        end

        drive_mask = ~(stat_mask | strobe_mask)
                   & {{(CW/2){~cfg.c_hi_in}}, {(CW/2){~cfg.c_lo_in}}};
    end

endmodule

// File: rtl/ppio_hs_chan.sv
module ppio_hs_chan #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en_in,
    input  logic          en_out,
    input  logic          stb_n,
    input  logic          ack_n,
    input  logic [DW-1:0] din,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic          ien_we_in,
    input  logic          ien_we_out,
    input  logic          ien_val,
    output logic [DW-1:0] in_data,
    output logic          in_full,
    output logic          out_full,
    output logic          irq_in,
    output logic          irq_out,
    output logic          ien_in,
    output logic          ien_out
);

    typedef struct packed {
        logic [DW-1:0] in_data;
        logic          in_full;
        logic          out_full;
        logic          irq_in;
        logic          irq_out;
        logic          ien_in;
        logic          ien_out;
        logic          stb_prev;
    } chan_t;

    chan_t s_d, s_q;

    always_comb begin
        s_d = s_q;

        if (ien_we_in) begin
            s_d.ien_in = ien_val;
        end
        if (ien_we_out) begin
            s_d.ien_out = ien_val;
        end

        s_d.stb_prev = stb_n | ~en_in;

        if (en_in) begin
            if (host_rd) begin
                s_d.in_full = 1'b0;
                s_d.irq_in  = 1'b0;
            end
            if (!stb_n) begin
                s_d.in_data = din;
                s_d.in_full = 1'b1;
            end else if (!s_q.stb_prev) begin
                s_d.irq_in = s_d.irq_in | s_q.ien_in;
            end
        end

        if (en_out) begin
            if (host_wr) begin
                s_d.out_full = 1'b1;
                s_d.irq_out  = 1'b0;
            end else if (!ack_n && s_q.out_full) begin
                s_d.out_full = 1'b0;
                s_d.irq_out  = s_q.ien_out;
            end
        end

        if (clr) begin
            s_d          = '0;
            s_d.stb_prev = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q          <= '0;
            s_q.stb_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_data  = s_q.in_data;
    assign in_full  = s_q.in_full;
    assign out_full = s_q.out_full;
    assign irq_in   = s_q.irq_in;
    assign irq_out  = s_q.irq_out;
    assign ien_in   = s_q.ien_in;
    assign ien_out  = s_q.ien_out;

endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
    import ppio_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [CW-1:0] pc_in,
    output logic [CW-1:0] pc_out,
    output logic [CW-1:0] pc_oe,
    output logic          irq_a,
    output logic          irq_b
);

    localparam int unsigned PINW = $clog2(CW);

    typedef struct packed {
        cfg_t          cfg;
        logic [DW-1:0] a_lat;
        logic [DW-1:0] b_lat;
        logic [CW-1:0] c_lat;
    } top_t;

    top_t st_d, st_q;

    // role decode
    logic          a_hs_in, a_hs_out, a_bidir, b_hs_in, b_hs_out;
    logic [CW-1:0] stat_mask, strobe_mask, drive_mask;

    ppio_role_decode u_roles (
        .cfg         (st_q.cfg),
        .a_hs_in     (a_hs_in),
        .a_hs_out    (a_hs_out),
        .a_bidir     (a_bidir),
        .b_hs_in     (b_hs_in),
        .b_hs_out    (b_hs_out),
        .stat_mask   (stat_mask),
        .strobe_mask (strobe_mask),
        .drive_mask  (drive_mask)
    );

    // bus decode
    logic            wr_hit, rd_hit, mode_wr, pin_wr, pin_val;
    logic [PINW-1:0] pin_sel;

    always_comb begin
        wr_hit  = cs & wr;
        rd_hit  = cs & rd;
        mode_wr = wr_hit & (addr == REG_CTL) & wdata[7];
        pin_wr  = wr_hit & (addr == REG_CTL) & ~wdata[7];
        pin_sel = wdata[PINW:1];
        pin_val = wdata[0];
    end

    // handshake channels: index 0 = port A, 1 = port B
    logic          ch_en_in  [NCH];
    logic          ch_en_out [NCH];
    logic          ch_stb_n  [NCH];
    logic          ch_ack_n  [NCH];
    logic [DW-1:0] ch_din    [NCH];
    logic          ch_rd     [NCH];
    logic          ch_wr     [NCH];
    logic          ch_we_in  [NCH];
    logic          ch_we_out [NCH];
    logic [DW-1:0] ch_data   [NCH];
    logic          ch_ifull  [NCH];
    logic          ch_ofull  [NCH];
    logic          ch_irq_i  [NCH];
    logic          ch_irq_o  [NCH];
    logic          ch_ien_i  [NCH];
    logic          ch_ien_o  [NCH];

    always_comb begin
        ch_en_in[0]  = a_hs_in;
        ch_en_out[0] = a_hs_out;
        ch_stb_n[0]  = pc_in[PIN_A_STB];
        ch_ack_n[0]  = pc_in[PIN_A_ACK];
        ch_din[0]    = pa_in;
        ch_we_in[0]  = pin_wr & a_hs_in  & (pin_sel == PINW'(PIN_A_STB));
        ch_we_out[0] = pin_wr & a_hs_out & (pin_sel == PINW'(PIN_A_ACK));

        ch_en_in[1]  = b_hs_in;
        ch_en_out[1] = b_hs_out;
        ch_stb_n[1]  = pc_in[PIN_B_HS];
        ch_ack_n[1]  = pc_in[PIN_B_HS];
        ch_din[1]    = pb_in;
        ch_we_in[1]  = pin_wr & st_q.cfg.b_hand & (pin_sel == PINW'(PIN_B_HS));
        ch_we_out[1] = ch_we_in[1];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign ch_rd[g] = rd_hit & (addr == 2'(g));
        assign ch_wr[g] = wr_hit & (addr == 2'(g));

        ppio_hs_chan #(.DW(DW)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .clr        (mode_wr),
            .en_in      (ch_en_in[g]),
            .en_out     (ch_en_out[g]),
            .stb_n      (ch_stb_n[g]),
            .ack_n      (ch_ack_n[g]),
            .din        (ch_din[g]),
            .host_rd    (ch_rd[g]),
            .host_wr    (ch_wr[g]),
            .ien_we_in  (ch_we_in[g]),
            .ien_we_out (ch_we_out[g]),
            .ien_val    (pin_val),
            .in_data    (ch_data[g]),
            .in_full    (ch_ifull[g]),
            .out_full   (ch_ofull[g]),
            .irq_in     (ch_irq_i[g]),
            .irq_out    (ch_irq_o[g]),
            .ien_in     (ch_ien_i[g]),
            .ien_out    (ch_ien_o[g])
        );
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (wr_hit && addr == REG_A) begin
            st_d.a_lat = wdata;
        end
        if (wr_hit && addr == REG_B) begin
            st_d.b_lat = wdata;
        end
        if (wr_hit && addr == REG_C) begin
            st_d.c_lat = wdata[CW-1:0];
        end
        if (pin_wr && !strobe_mask[pin_sel]) begin
            st_d.c_lat[pin_sel] = pin_val;
        end
        if (mode_wr) begin
            st_d.cfg   = cfg_t'(wdata[7:0]);
            st_d.a_lat = '0;
            st_d.b_lat = '0;
            st_d.c_lat = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cfg   <= CFG_RESET;
            st_q.a_lat <= '0;
            st_q.b_lat <= '0;
            st_q.c_lat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // outputs
    logic [CW-1:0] c_stat, c_read;
    logic          a_plain;

    always_comb begin
        a_plain = (st_q.cfg.a_mode == 2'b00);
        irq_a   = ch_irq_i[0] | ch_irq_o[0];
        irq_b   = ch_irq_i[1] | ch_irq_o[1];

        c_stat             = '0;
        c_stat[PIN_B_IRQ]  = irq_b;
        c_stat[PIN_B_FLAG] = b_hs_in ? ch_ifull[1] : ~ch_ofull[1];
        c_stat[PIN_A_IRQ]  = irq_a;
        c_stat[PIN_A_IBF]  = ch_ifull[0];
        c_stat[PIN_A_OBF]  = ~ch_ofull[0];

        pa_out = st_q.a_lat;
        if (a_bidir) begin
            pa_oe = {DW{~pc_in[PIN_A_ACK]}};
        end else if (a_hs_out || (a_plain && !st_q.cfg.a_in)) begin
            pa_oe = '1;
        end else begin
            pa_oe = '0;
        end

        pb_out = st_q.b_lat;
        pb_oe  = st_q.cfg.b_in ? '0 : '1;

        pc_out = (stat_mask & c_stat) | (~stat_mask & st_q.c_lat);
        pc_oe  = stat_mask | drive_mask;

        c_read = (stat_mask & c_stat)
               | (drive_mask & st_q.c_lat)
               | (~(stat_mask | drive_mask) & pc_in);

        unique case (addr)
            REG_A: begin
                if (a_hs_in) begin
                    rdata = ch_data[0];
                end else if (a_plain && st_q.cfg.a_in) begin
                    rdata = pa_in;
                end else begin
                    rdata = st_q.a_lat;
                end
            end
            REG_B: begin
                if (b_hs_in) begin
                    rdata = ch_data[1];
                end else if (st_q.cfg.b_in) begin
                    rdata = pb_in;
                end else begin
                    rdata = st_q.b_lat;
                end
            end
            REG_C:   rdata = DW'(c_read);
            default: rdata = DW'(st_q.cfg);
        endcase
    end

    // observation points for the bound checker
    logic [CW-1:0] c_lat_q;
    logic          ien_a_any, ien_b_any;

    assign c_lat_q   = st_q.c_lat;
    assign ien_a_any = ch_ien_i[0] | ch_ien_o[0];
    assign ien_b_any = ch_ien_i[1] | ch_ien_o[1];

endmodule

// File: rtl/ppio_ctrl_sva.sv
module ppio_ctrl_sva
    import ppio_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          cs,
    input logic          wr,
    input logic [1:0]    addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] pa_out,
    input logic [DW-1:0] pb_out,
    input logic [CW-1:0] pc_in,
    input logic [CW-1:0] pc_out,
    input logic [CW-1:0] pc_oe,
    input logic          irq_a,
    input logic          irq_b,
    input logic          a_hs_in,
    input logic          a_hs_out,
    input logic [CW-1:0] strobe_mask,
    input logic [CW-1:0] c_lat_q,
    input logic          ien_a_any,
    input logic          ien_b_any
);

    logic ctl_wr;
    assign ctl_wr = cs && wr && (addr == REG_CTL);

    // R2: a mode word empties latches and interrupts
    a_r2_modeset_clears: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wdata[7]) |=> (pa_out == '0 && pb_out == '0 && !irq_a && !irq_b));

    // R6: single-pin word lands in the selected latch bit
    a_r6_pin_write: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !wdata[7] && !strobe_mask[wdata[3:1]])
        |=> (c_lat_q[$past(wdata[3:1])] == $past(wdata[0])));

    // R7: strobe low on port A fills the input buffer
    a_r7_strobe_fills: assert property (@(posedge clk) disable iff (rst)
        (a_hs_in && !pc_in[PIN_A_STB] && !ctl_wr) |=> pc_out[PIN_A_IBF]);

    // R8: an interrupt only rises when it was armed
    a_r8_irq_a_armed: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_a) |-> $past(ien_a_any));
    a_r8_irq_b_armed: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_b) |-> $past(ien_b_any));

    // R9: acknowledge empties port A output buffer
    a_r9_ack_drains: assert property (@(posedge clk) disable iff (rst)
        (a_hs_out && !pc_in[PIN_A_ACK] && !(cs && wr)) |=> pc_out[PIN_A_OBF]);

    // R11: strobe and acknowledge pins are never driven
    a_r11_strobe_undriven: assert property (@(posedge clk) disable iff (rst)
        ((pc_oe & strobe_mask) == '0));

endmodule

bind ppio_ctrl ppio_ctrl_sva #(.DW(DW)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .cs          (cs),
    .wr          (wr),
    .addr        (addr),
    .wdata       (wdata),
    .pa_out      (pa_out),
    .pb_out      (pb_out),
    .pc_in       (pc_in),
    .pc_out      (pc_out),
    .pc_oe       (pc_oe),
    .irq_a       (irq_a),
    .irq_b       (irq_b),
    .a_hs_in     (a_hs_in),
    .a_hs_out    (a_hs_out),
    .strobe_mask (strobe_mask),
    .c_lat_q     (c_lat_q),
    .ien_a_any   (ien_a_any),
    .ien_b_any   (ien_b_any)
);

// File: tb/ppio_ctrl_bench.sv
module ppio_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00, pa_out, pa_oe;
    logic [7:0] pb_in = 8'h00, pb_out, pb_oe;
    logic [7:0] pc_drv = 8'hFF, pc_out, pc_oe;
    logic       irq_a, irq_b;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    ppio_ctrl u_ppio_ctrl (
        .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_drv), .pc_out(pc_out), .pc_oe(pc_oe),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic pulse_pin(input int p);
        @(negedge clk);
        pc_drv[p] = 1'b0;
        @(negedge clk);
        pc_drv[p] = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        chk("R1 irq", {irq_a, irq_b}, 2'b00);
        bus_rd(2'd3, d);
        chk("R1 ctl", d, 8'hF4);
    endtask

    task automatic t_plain_out();
        logic [7:0] d;
        bus_wr(2'd3, 8'h80);
        bus_wr(2'd0, 8'h3C);
        bus_wr(2'd1, 8'hC3);
        bus_wr(2'd2, 8'h96);
        chk("R3 pa_out", pa_out, 8'h3C);
        chk("R3 pa_oe", pa_oe, 8'hFF);
        chk("R3 pb_out", {pb_out, pb_oe}, 16'hC3FF);
        chk("R3 pc_out", {pc_out, pc_oe}, 16'h96FF);
        bus_rd(2'd0, d);
        chk("R3 read A", d, 8'h3C);
    endtask

    task automatic t_plain_in();
        logic [7:0] d;
        bus_wr(2'd3, 8'hB0);
        chk("R4 pb_oe", pb_oe, 8'h00);
        pb_in = 8'h11;
        bus_rd(2'd1, d);
        chk("R4 read B first", d, 8'h11);
        pb_in = 8'h22;
        bus_rd(2'd1, d);
        chk("R4 read B live", d, 8'h22);
        chk("R5 pc_oe", pc_oe, 8'hF0);
        bus_wr(2'd2, 8'hAB);
        pc_drv = 8'hF5;
        bus_rd(2'd2, d);
        chk("R5 read C", d, 8'hA5);
        chk("R5 pc_out hi", pc_out[7:4], 4'hA);
        pc_drv = 8'hFF;
    endtask

    task automatic t_pin_word();
        logic [7:0] d;
        bus_wr(2'd3, 8'h80);
        bus_wr(2'd0, 8'h55);
        bus_wr(2'd3, 8'h0B);
        chk("R6 set pin5", pc_out, 8'h20);
        bus_wr(2'd3, 8'h01);
        chk("R6 set pin0", pc_out, 8'h21);
        bus_wr(2'd3, 8'h0A);
        chk("R6 clear pin5", pc_out, 8'h01);
        bus_wr(2'd3, 8'h80);
        chk("R2 clears C", pc_out, 8'h00);
        chk("R2 clears A", pa_out, 8'h00);
        bus_rd(2'd3, d);
        chk("R2 ctl readback", d, 8'h80);
    endtask

    task automatic t_hs_in_a();
        logic [7:0] d;
        bus_wr(2'd3, 8'h8D);
        chk("R11 pc_oe", pc_oe, 8'hEB);
        chk("R7 pa_oe", pa_oe, 8'h00);
        pa_in = 8'h77;
        pulse_pin(4);
        pa_in = 8'h00;
        chk("R7 full set", pc_out[5], 1'b1);
        chk("R8 no irq disarmed", irq_a, 1'b0);
        bus_rd(2'd0, d);
        chk("R7 held data", d, 8'h77);
        chk("R7 full cleared", pc_out[5], 1'b0);
        bus_wr(2'd3, 8'h09);
        pa_in = 8'h42;
        pulse_pin(4);
        chk("R8 irq armed", {irq_a, pc_out[3]}, 2'b11);
        bus_rd(2'd0, d);
        chk("R8 read data", d, 8'h42);
        chk("R8 read clears irq", irq_a, 1'b0);
        // port B handshake output in the same configuration
        bus_wr(2'd3, 8'h05);
        bus_wr(2'd1, 8'h5C);
        chk("R9 B out", {pb_out, pb_oe}, 16'h5CFF);
        chk("R9 B full low", pc_out[1], 1'b0);
        pulse_pin(2);
        chk("R9 B ack", {pc_out[1], irq_b, pc_out[0]}, 3'b111);
        bus_wr(2'd2, 8'hC0);
        chk("R11 ordinary hi pins", pc_out[7:6], 2'b11);
    endtask

    task automatic t_hs_out_a();
        logic [7:0] d;
        bus_wr(2'd3, 8'hD9);
        chk("R11 pc_oe out/in", pc_oe, 8'h4B);
        chk("R9 pa_oe", pa_oe, 8'hFF);
        bus_wr(2'd0, 8'h5A);
        chk("R9 pa_out", pa_out, 8'h5A);
        chk("R9 full low", pc_out[6], 1'b0);
        pulse_pin(7);
        chk("R9 ack empties", pc_out[6], 1'b1);
        chk("R9 no irq disarmed", irq_a, 1'b0);
        bus_wr(2'd3, 8'h0F);
        bus_wr(2'd0, 8'h66);
        pulse_pin(7);
        chk("R9 irq armed", irq_a, 1'b1);
        bus_wr(2'd0, 8'h11);
        chk("R9 write clears irq", {irq_a, pc_out[6]}, 2'b00);
        // port B handshake input
        bus_wr(2'd3, 8'h05);
        pb_in = 8'h9E;
        pulse_pin(2);
        pb_in = 8'h00;
        chk("R7 B full", pc_out[1], 1'b1);
        chk("R8 B irq", irq_b, 1'b1);
        bus_rd(2'd1, d);
        chk("R7 B data", d, 8'h9E);
        chk("R8 B cleared", {irq_b, pc_out[1]}, 2'b00);
        pc_drv[5:4] = 2'b10;
        bus_rd(2'd2, d);
        chk("R11 read C mixed", d, 8'hA4);
        pc_drv = 8'hFF;
    endtask

    task automatic t_bidir();
        logic [7:0] d;
        bus_wr(2'd3, 8'h82);
        chk("R10 pc_oe", pc_oe, 8'h6F);
        chk("R10 idle pa_oe", pa_oe, 8'h00);
        bus_wr(2'd0, 8'h81);
        chk("R10 full low", pc_out[6], 1'b0);
        @(negedge clk);
        pc_drv[7] = 1'b0;
        #1;
        chk("R10 drive on ack", {pa_oe, pa_out}, 16'hFF81);
        @(negedge clk);
        pc_drv[7] = 1'b1;
        #1;
        chk("R10 released", pa_oe, 8'h00);
        chk("R10 full cleared", pc_out[6], 1'b1);
        pa_in = 8'h3F;
        pulse_pin(4);
        chk("R10 in full", pc_out[5], 1'b1);
        bus_rd(2'd0, d);
        chk("R10 in data", d, 8'h3F);
        bus_wr(2'd3, 8'h09);
        pa_in = 8'h5D;
        pulse_pin(4);
        chk("R10 irq on C3", {pc_out[3], irq_a}, 2'b11);
        bus_wr(2'd2, 8'h07);
        chk("R10 low pins ordinary", pc_out[2:0], 3'b111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain_out();
        t_plain_in();
        t_pin_word();
        t_hs_in_a();
        t_hs_out_a();
        t_bidir();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule